// File: doc/BRIEF.md
# Packet Timestamp Capture Queue

This block records the time at which precision-timing event packets pass their start-of-packet point, in either the transmit or the receive direction. A header parser upstream supplies a start-of-packet strobe together with the packet's 4-bit message type, its 16-bit sequence number and a direction flag. The block samples the free-running 64-bit time value (32-bit seconds, 32-bit nanoseconds) on that strobe. It then stores one record in an eight-entry queue. Capture happens only when the global time-sync enable is set and the enable for the strobe's direction is also set.

A host reaches the queue through a small word-wide register port. A status bit tells the host that records are waiting. The host copies the oldest record into a set of readout words with a start command, which freezes it there. It reads the words at leisure. It then releases the record with an end command followed by a write of zero, and only that step removes the record from the queue. A capture that finds the queue full is discarded and sets a sticky overflow flag.

Top module: `ptp_stamp_queue`

## Requirements
- R1: After reset the status word, every readout word and every control register read as zero.
- R2: A strobe marked transmit (sop_tx=1) is stored only when the transmit enable (control register 0x0 bit 0) is set. A strobe marked receive is stored only when the receive enable (control register 0x0 bit 8) is set. Otherwise the strobe leaves no record.
- R3: While the global enable (register 0x1 bit 0) is clear, no strobe is stored, whatever the direction enables.
- R4: Status register 0x3 bit 1 reads 1 exactly when at least one record is queued. It is updated on the clock edge that stores or removes a record.
- R5: Writing bit 0 of the read-control register 0x2 copies the oldest record into the readout words. Word 0x4 holds nanoseconds[15:0], 0x5 holds nanoseconds[31:16], 0x6 holds seconds[15:0] and 0x7 holds seconds[31:16]. Word 0x8 holds the sequence number. Word 0x9 holds the message type in bits 15:12 and the transmit flag in bit 11, with all other bits zero.
- R6: Once frozen, the readout words do not change until the next start command, even while new records are captured.
- R7: A write of 0x2 to register 0x2 after a start, followed by a write of 0x0, removes exactly the frozen record. Records leave in the order they were captured.
- R8: A strobe that qualifies while eight records are queued is dropped, and the queue keeps its contents. The drop sets status bit 2, which stays set until the host writes 1 to bit 2 of register 0x3.
- R9: A start command while the queue is empty sets all readout words to zero and leaves the queue unchanged.
- R10: A write of zero to register 0x2 that is not preceded by an end command after the start removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_now | input | 64 | Current time, seconds in [63:32], nanoseconds in [31:0] |
| sop | input | 1 | Start-of-packet strobe for an event packet, one cycle |
| sop_tx | input | 1 | Direction of the strobed packet, 1 = transmit |
| sop_msg_type | input | 4 | Message type of the strobed packet |
| sop_seq_id | input | 16 | Sequence number of the strobed packet |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |

## Verification
The embedded properties assume a few things about the inputs. The strobe is a one-cycle pulse whose metadata and time value are valid in that cycle. Register writes are single-cycle pulses, and every pop request arrives through the read-control handshake rather than by any other path. The bench follows these rules. It drives every input on the falling edge, holds the strobe and each write for exactly one cycle, and only moves the handshake through the order start, end, zero or deliberately short-cuts it for the zero-without-end case. It also fills the queue past its depth only through qualified strobes, so the overflow path is reached the same way the hardware would reach it.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] nsec;
    logic [15:0] seq;
    logic [3:0]  mtype;
    logic        is_tx;
  } stamp_rec_t;

  localparam int unsigned REC_W = $bits(stamp_rec_t);

  localparam logic [3:0] A_DIR_EN   = 4'h0;
  localparam logic [3:0] A_GLOBAL   = 4'h1;
  localparam logic [3:0] A_RD_CTRL  = 4'h2;
  localparam logic [3:0] A_STATUS   = 4'h3;
  localparam logic [3:0] A_NS_LO    = 4'h4;
  localparam logic [3:0] A_NS_HI    = 4'h5;
  localparam logic [3:0] A_SEC_LO   = 4'h6;
  localparam logic [3:0] A_SEC_HI   = 4'h7;
  localparam logic [3:0] A_SEQ      = 4'h8;
  localparam logic [3:0] A_INFO     = 4'h9;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_FROZEN = 2'd1,
    RD_ENDING = 2'd2
  } rd_state_e;

endpackage

// File: rtl/tsq_capture.sv
module tsq_capture (
  input  logic sop,
  input  logic sop_tx,
  input  logic en_tx,
  input  logic en_rx,
  input  logic en_global,
  input  logic full,
  output logic push,
  output logic drop
);

  logic dir_ok;
  logic hit;

  always_comb begin
    dir_ok = sop_tx ? en_tx : en_rx;
    hit    = sop & en_global & dir_ok;
    push   = hit & ~full;
    drop   = hit & full;
  end

  always_comb begin
    if (push) assert_push_enabled_R3: assert (en_global && (sop_tx ? en_tx : en_rx));
  end

endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  tsq_pkg::stamp_rec_t wr_rec,
  input  logic                pop,
  output tsq_pkg::stamp_rec_t head,
  output logic                empty,
  output logic                full
);
  import tsq_pkg::*;

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  stamp_rec_t       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  always_comb begin
    empty    = (cnt_q == '0);
    full     = (cnt_q == CAP);
    do_wr    = push & ~full;
    do_rd    = pop & ~empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_wr) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (do_rd) rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    head = mem_q[rd_ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_wr && (wr_ptr_q == PTR_W'(i))) mem_q[i] <= wr_rec;
    end
  end

  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

// File: rtl/tsq_readout.sv
module tsq_readout (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_wr,
  input  logic                end_wr,
  input  logic                zero_wr,
  input  tsq_pkg::stamp_rec_t head,
  input  logic                empty,
  output logic                pop,
  output tsq_pkg::stamp_rec_t snap
);
  import tsq_pkg::*;

  rd_state_e  st_q, st_d;
  stamp_rec_t snap_q, snap_d;
  logic       held_q, held_d;

  always_comb begin
    st_d   = st_q;
    snap_d = snap_q;
    held_d = held_q;
    pop    = 1'b0;
    if (start_wr) begin
      snap_d = empty ? '0 : head;
      held_d = ~empty;
      st_d   = RD_FROZEN;
    end else begin
      case (st_q)
        RD_FROZEN: if (end_wr) st_d = RD_ENDING;
        RD_ENDING: if (zero_wr) begin
          pop    = held_q;
          held_d = 1'b0;
          st_d   = RD_IDLE;
        end
        default: st_d = RD_IDLE;
      endcase
    end
    snap = snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      snap_q <= '0;
      held_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      snap_q <= snap_d;
      held_q <= held_d;
    end
  end

  assert_snap_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start_wr |=> $stable(snap_q));
  assert_pop_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (st_q == RD_ENDING));
  assert_empty_snap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && empty) |=> (snap_q == '0));

endmodule

// File: rtl/ptp_stamp_queue.sv
module ptp_stamp_queue #(
  parameter int unsigned DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] time_now,
  input  logic        sop,
  input  logic        sop_tx,
  input  logic [3:0]  sop_msg_type,
  input  logic [15:0] sop_seq_id,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  import tsq_pkg::*;

  logic       en_tx_q, en_tx_d;
  logic       en_rx_q, en_rx_d;
  logic       en_glb_q, en_glb_d;
  logic       ovf_q, ovf_d;
  logic       push, drop, pop, empty, full;
  logic       start_wr, end_wr, zero_wr, ovf_clr;
  stamp_rec_t new_rec, head, snap;

  always_comb begin
    new_rec.sec   = time_now[63:32];
    new_rec.nsec  = time_now[31:0];
    new_rec.seq   = sop_seq_id;
    new_rec.mtype = sop_msg_type;
    new_rec.is_tx = sop_tx;
  end

  always_comb begin
    start_wr = reg_we && (reg_addr == A_RD_CTRL) && reg_wdata[0];
    end_wr   = reg_we && (reg_addr == A_RD_CTRL) && !reg_wdata[0] && reg_wdata[1];
    zero_wr  = reg_we && (reg_addr == A_RD_CTRL) && (reg_wdata[1:0] == 2'b00);
    ovf_clr  = reg_we && (reg_addr == A_STATUS) && reg_wdata[2];
    en_tx_d  = en_tx_q;
    en_rx_d  = en_rx_q;
    en_glb_d = en_glb_q;
    if (reg_we && (reg_addr == A_DIR_EN)) begin
      en_tx_d = reg_wdata[0];
      en_rx_d = reg_wdata[8];
    end
    if (reg_we && (reg_addr == A_GLOBAL)) en_glb_d = reg_wdata[0];
    ovf_d = drop ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_tx_q  <= 1'b0;
      en_rx_q  <= 1'b0;
      en_glb_q <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      en_tx_q  <= en_tx_d;
      en_rx_q  <= en_rx_d;
      en_glb_q <= en_glb_d;
      ovf_q    <= ovf_d;
    end
  end

  tsq_capture u_capture (
    .sop       (sop),
    .sop_tx    (sop_tx),
    .en_tx     (en_tx_q),
    .en_rx     (en_rx_q),
    .en_global (en_glb_q),
    .full      (full),
    .push      (push),
    .drop      (drop)
  );

  tsq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .wr_rec (new_rec),
    .pop    (pop),
    .head   (head),
    .empty  (empty),
    .full   (full)
  );

  tsq_readout u_readout (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_wr (start_wr),
    .end_wr   (end_wr),
    .zero_wr  (zero_wr),
    .head     (head),
    .empty    (empty),
    .pop      (pop),
    .snap     (snap)
  );

  always_comb begin
    case (reg_addr)
      A_DIR_EN:  reg_rdata = {7'b0, en_rx_q, 7'b0, en_tx_q};
      A_GLOBAL:  reg_rdata = {15'b0, en_glb_q};
      A_STATUS:  reg_rdata = {13'b0, ovf_q, ~empty, 1'b0};
      A_NS_LO:   reg_rdata = snap.nsec[15:0];
      A_NS_HI:   reg_rdata = snap.nsec[31:16];
      A_SEC_LO:  reg_rdata = snap.sec[15:0];
      A_SEC_HI:  reg_rdata = snap.sec[31:16];
      A_SEQ:     reg_rdata = snap.seq;
      A_INFO:    reg_rdata = {snap.mtype, snap.is_tx, 11'b0};
      default:   reg_rdata = 16'h0000;
    endcase
  end

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  assert_drop_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);
  assert_pending_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !empty);

endmodule

// File: tb/ptp_stamp_queue_bench.sv
module ptp_stamp_queue_bench;
  import tsq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = '0;
  logic        sop = 1'b0;
  logic        sop_tx = 1'b0;
  logic [3:0]  sop_msg_type = '0;
  logic [15:0] sop_seq_id = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit m_tx = 0, m_rx = 0, m_glb = 0, m_ovf = 0;
  stamp_rec_t exp_q[$];

  always #5 clk = ~clk;

  ptp_stamp_queue u_ptp_stamp_queue (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .sop(sop), .sop_tx(sop_tx),
    .sop_msg_type(sop_msg_type), .sop_seq_id(sop_seq_id), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == A_DIR_EN) begin m_tx = d[0]; m_rx = d[8]; end
    if (a == A_GLOBAL) m_glb = d[0];
    if (a == A_STATUS && d[2]) m_ovf = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // driver: strobes one packet and pushes the expected record into the scoreboard
  task automatic capture(input bit tx, input logic [15:0] seq, input logic [3:0] mt,
                         input logic [31:0] s, input logic [31:0] ns);
    stamp_rec_t r;
    @(negedge clk);
    sop = 1'b1; sop_tx = tx; sop_seq_id = seq; sop_msg_type = mt; time_now = {s, ns};
    @(negedge clk);
    sop = 1'b0;
    if (m_glb && (tx ? m_tx : m_rx)) begin
      if (exp_q.size() < 8) begin
        r.sec = s; r.nsec = ns; r.seq = seq; r.mtype = mt; r.is_tx = tx;
        exp_q.push_back(r);
      end else m_ovf = 1;
    end
  endtask

  task automatic check_words(input string req, input stamp_rec_t e);
    logic [15:0] v;
    rd(A_NS_LO, v);  chk(req, v, e.nsec[15:0]);
    rd(A_NS_HI, v);  chk(req, v, e.nsec[31:16]);
    rd(A_SEC_LO, v); chk(req, v, e.sec[15:0]);
    rd(A_SEC_HI, v); chk(req, v, e.sec[31:16]);
    rd(A_SEQ, v);    chk(req, v, e.seq);
    rd(A_INFO, v);   chk(req, v, {e.mtype, e.is_tx, 11'b0});
  endtask

  task automatic check_status(input string req);
    logic [15:0] v;
    rd(A_STATUS, v);
    chk(req, v, {13'b0, m_ovf, (exp_q.size() != 0), 1'b0});
  endtask

  // monitor: full handshake, compares against the scoreboard head and pops it
  task automatic pop_check(input string req);
    stamp_rec_t e;
    e = (exp_q.size() != 0) ? exp_q[0] : '0;
    wr(A_RD_CTRL, 16'h0001);
    check_words(req, e);
    wr(A_RD_CTRL, 16'h0002);
    wr(A_RD_CTRL, 16'h0000);
    if (exp_q.size() != 0) void'(exp_q.pop_front());
    check_status(req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] v;
    stamp_rec_t e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_STATUS, v); chk("R1 status", v, 16'h0);
    rd(A_DIR_EN, v); chk("R1 dir", v, 16'h0);
    rd(A_GLOBAL, v); chk("R1 global", v, 16'h0);
    check_words("R1 words", '0);

    // R2/R4 transmit only
    wr(A_GLOBAL, 16'h0001);
    wr(A_DIR_EN, 16'h0001);
    capture(1, 16'h1234, 4'h0, 32'h0000_00AA, 32'h1122_3344);
    check_status("R4 pending");
    capture(0, 16'h5555, 4'h1, 32'h1, 32'h2);
    check_status("R2 rx ignored");
    pop_check("R5 R7 tx record");

    // R2 receive, R3 global off
    wr(A_DIR_EN, 16'h0100);
    capture(0, 16'hBEEF, 4'h3, 32'hCAFE_0001, 32'h3B9A_C9FF);
    capture(1, 16'h0007, 4'h2, 32'h5, 32'h6);
    check_status("R2 rx stored");
    pop_check("R2 rx record");
    wr(A_DIR_EN, 16'h0101);
    wr(A_GLOBAL, 16'h0000);
    capture(1, 16'h0101, 4'h0, 32'h9, 32'h9);
    capture(0, 16'h0102, 4'h0, 32'h9, 32'h9);
    check_status("R3 global off");
    wr(A_GLOBAL, 16'h0001);

    // R7 ordering
    for (int i = 0; i < 3; i++)
      capture(i[0], 16'(16'h2000 + i), 4'(i + 8), 32'(100 + i), 32'(7000 + i));
    for (int i = 0; i < 3; i++) pop_check("R7 order");

    // R6 frozen snapshot survives new captures
    capture(1, 16'hA001, 4'hC, 32'hDEAD_0000, 32'h0000_BEEF);
    e0 = exp_q[0];
    wr(A_RD_CTRL, 16'h0001);
    capture(0, 16'hA002, 4'hD, 32'h1111_2222, 32'h3333_4444);
    check_words("R6 frozen", e0);
    // R10 zero without end does not pop
    wr(A_RD_CTRL, 16'h0000);
    check_status("R10 no pop");
    pop_check("R10 head kept");
    pop_check("R6 second record");

    // R8 overflow
    for (int i = 0; i < 9; i++)
      capture(1, 16'(16'h3000 + i), 4'(i), 32'(i * 3), 32'(i * 5 + 1));
    check_status("R8 overflow set");
    for (int i = 0; i < 8; i++) pop_check("R8 retained");
    rd(A_STATUS, v); chk("R8 sticky", v, 16'h0004);
    wr(A_STATUS, 16'h0004);
    check_status("R8 cleared");

    // R9 read start on empty queue
    wr(A_RD_CTRL, 16'h0001);
    check_words("R9 zeros", '0);
    wr(A_RD_CTRL, 16'h0002);
    wr(A_RD_CTRL, 16'h0000);
    check_status("R9 unchanged");
    capture(0, 16'h4444, 4'h5, 32'h7777_8888, 32'h0000_0010);
    pop_check("R9 after empty read");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule